// File: doc/BRIEF.md
# SDRAM Bank Activation Timing Guard

This block watches the command stream that a memory controller drives toward a four-bank SDRAM. On every rising clock edge it decodes the command from the active-low chip-select, RAS, CAS and WE pins, together with the bank-select and row-address inputs. For each bank it keeps track of whether the bank is open and which row is open in it. It checks each command against four timing limits: RAS-to-CAS delay, row cycle time, activate-to-activate delay across banks, and maximum row-open time.

A command that breaks a rule is rejected, so the tracked state stays the same. The rejection is reported one cycle later as a single-cycle error pulse, with a code and the number of the bank at fault. A combinational flag tells the controller, in the same cycle, whether the command currently on the pins would be accepted. This lets the flag serve as a pre-issue gate.

All timing limits are counted in clock edges and set by parameters. The first edge after the activate edge is edge 1.

Top module: `sdram_act_guard`

## Requirements
- R1: With cs_ni low, {ras_ni,cas_ni,we_ni} decodes as 011 = activate, 101 = read, 100 = write and 010 = precharge. Any other pattern, and every pattern with cs_ni high, is a no-op.
- R2: An accepted activate opens the bank given by bank_i (0 to 3). The bank is shown on open_o[bank_i], and addr_i[11:0] is stored as that bank's row on open_rows_o[12*bank_i +: 12].
- R3: An activate to a bank that is already open is rejected with error code 5.
- R4: A precharge closes its bank. A precharge to a closed bank is accepted with no error.
- R5: A read or write is rejected with code 1 if its bank is closed, or if the command comes sooner than edge TRCD after that bank's activate. At edge TRCD it is accepted.
- R6: An activate to a bank sooner than edge TRC after the previous activate of that same bank is rejected with code 2.
- R7: An activate to a bank other than the bank of the last accepted activate, sooner than edge TRRD after that activate, is rejected with code 3. Rejected activates do not restart this window.
- R8: If a bank is still open at edge TRAS_MAX+1 after its activate, and no precharge to it arrives at that edge, one error with code 4 and that bank is reported.
- R9: A rejected command or a no-op changes neither open_o nor open_rows_o.
- R10: err_o is registered. It is high for exactly the cycle after the offending edge, with err_code_o and err_bank_o valid. Otherwise err_code_o is 0. A command error takes precedence over a code-4 error at the same edge.
- R11: cmd_ok_o is high, in the same cycle, exactly when the command on the pins would be accepted. It is always high for a no-op.
- R12: After reset all banks are closed and all counters are saturated, so any first activate is legal at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| bank_i | input | 2 | Bank select |
| addr_i | input | 12 | Row address used by activate |
| cmd_ok_o | output | 1 | Command on the pins would be accepted |
| open_o | output | 4 | Open flag per bank |
| open_rows_o | output | 48 | Open row per bank, 12 bits each |
| err_o | output | 1 | Single-cycle error pulse |
| err_code_o | output | 3 | 1 RCD, 2 RC, 3 RRD, 4 RAS max, 5 activate of open bank |
| err_bank_o | output | 2 | Bank at fault |

## Verification
Reads and writes are placed one edge before and exactly at the RAS-to-CAS boundary. This separates an off-by-one in the delay counter from a correct one. A read to a closed bank and a re-activate of an open bank show the state-based rejections apart from the timing-based ones.

Activates are sent to a second bank on consecutive edges to exercise the cross-bank window. The same bank is re-activated after a quick precharge to exercise the row cycle window. A long idle run with no precharge is compared against one where the precharge lands on the very edge at which the limit would fire.

Chip-select-high and refresh-like patterns confirm that no-ops leave the state alone.

// File: rtl/sag_pkg.sv
package sag_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4
  } cmd_e;

  typedef enum logic [2:0] {
    ERR_NONE    = 3'd0,
    ERR_RCD     = 3'd1,
    ERR_RC      = 3'd2,
    ERR_RRD     = 3'd3,
    ERR_RASMAX  = 3'd4,
    ERR_ACTOPEN = 3'd5
  } err_e;
endpackage

// File: rtl/sag_decode.sv
module sag_decode
  import sag_pkg::*;
(
  input  logic cs_ni,
  input  logic ras_ni,
  input  logic cas_ni,
  input  logic we_ni,
  output cmd_e cmd_o
);
  always_comb begin
    cmd_o = CMD_NOP;
    if (!cs_ni) begin
      unique case ({ras_ni, cas_ni, we_ni})
        3'b011:  cmd_o = CMD_ACT;
        3'b101:  cmd_o = CMD_RD;
        3'b100:  cmd_o = CMD_WR;
        3'b010:  cmd_o = CMD_PRE;
        default: cmd_o = CMD_NOP;
      endcase
    end
  end
endmodule

// File: rtl/sag_bank.sv
module sag_bank #(
  parameter int RW  = 12,
  parameter int CW  = 8,
  parameter int SAT = 100
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          act_i,
  input  logic          pre_i,
  input  logic [RW-1:0] row_i,
  output logic          open_o,
  output logic [RW-1:0] row_o,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] SAT_C = CW'(SAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_o <= 1'b0;
      row_o  <= '0;
      cnt_o  <= SAT_C;
    end else begin
      if (act_i) begin
        open_o <= 1'b1;
        row_o  <= row_i;
        cnt_o  <= CW'(1);
      end else begin
        if (pre_i) open_o <= 1'b0;
        if (cnt_o < SAT_C) cnt_o <= cnt_o + CW'(1);
      end
    end
  end
endmodule

// File: rtl/sag_rrd.sv
module sag_rrd #(
  parameter int BW   = 2,
  parameter int TRRD = 2,
  localparam int RCW = $clog2(TRRD + 1) + 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           act_i,
  input  logic [BW-1:0]  bank_i,
  output logic [RCW-1:0] cnt_o,
  output logic [BW-1:0]  last_bank_o
);
  localparam logic [RCW-1:0] SAT_C = RCW'(TRRD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o       <= SAT_C;
      last_bank_o <= '0;
    end else if (act_i) begin
      cnt_o       <= RCW'(1);
      last_bank_o <= bank_i;
    end else if (cnt_o < SAT_C) begin
      cnt_o <= cnt_o + RCW'(1);
    end
  end
endmodule

// File: rtl/sag_rules.sv
module sag_rules
  import sag_pkg::*;
#(
  parameter int NB       = 4,
  parameter int BW       = 2,
  parameter int CW       = 8,
  parameter int RCW      = 3,
  parameter int TRCD     = 3,
  parameter int TRC      = 9,
  parameter int TRRD     = 2,
  parameter int TRAS_MAX = 100
) (
  input  cmd_e                  cmd_i,
  input  logic [BW-1:0]         bank_i,
  input  logic [NB-1:0]         open_i,
  input  logic [NB-1:0][CW-1:0] cnt_i,
  input  logic [RCW-1:0]        rrd_cnt_i,
  input  logic [BW-1:0]         last_bank_i,
  output err_e                  code_o,
  output logic [NB-1:0]         act_go_o,
  output logic [NB-1:0]         pre_go_o,
  output logic [NB-1:0]         ras_hit_o
);
  localparam logic [CW-1:0]  TRCD_C  = CW'(TRCD);
  localparam logic [CW-1:0]  TRC_C   = CW'(TRC);
  localparam logic [CW-1:0]  RASX_C  = CW'(TRAS_MAX + 1);
  localparam logic [RCW-1:0] TRRD_C  = RCW'(TRRD);

  logic [CW-1:0] sel_cnt;
  logic          sel_open;

  assign sel_cnt  = cnt_i[bank_i];
  assign sel_open = open_i[bank_i];

  always_comb begin
    code_o = ERR_NONE;
    unique case (cmd_i)
      CMD_ACT: begin
        if (sel_open)                                   code_o = ERR_ACTOPEN;
        else if (sel_cnt < TRC_C)                       code_o = ERR_RC;
        else if (last_bank_i != bank_i && rrd_cnt_i < TRRD_C) code_o = ERR_RRD;
      end
      CMD_RD, CMD_WR: begin
        if (!sel_open || sel_cnt < TRCD_C)              code_o = ERR_RCD;
      end
      default: code_o = ERR_NONE;
    endcase
  end

  for (genvar b = 0; b < NB; b++) begin : g_bank
    assign act_go_o[b]  = (cmd_i == CMD_ACT) && (code_o == ERR_NONE) && (bank_i == BW'(b));
    assign pre_go_o[b]  = (cmd_i == CMD_PRE) && (bank_i == BW'(b));
    assign ras_hit_o[b] = open_i[b] && (cnt_i[b] == RASX_C) && !pre_go_o[b];
  end
endmodule

// File: rtl/sdram_act_guard.sv
module sdram_act_guard
  import sag_pkg::*;
#(
  parameter int NB       = 4,
  parameter int RW       = 12,
  parameter int TRCD     = 3,
  parameter int TRC      = 9,
  parameter int TRRD     = 2,
  parameter int TRAS_MAX = 12000,
  localparam int BW      = $clog2(NB),
  localparam int SAT0    = (TRC > TRCD) ? TRC : TRCD,
  localparam int SAT     = (SAT0 > TRAS_MAX + 2) ? SAT0 : TRAS_MAX + 2,
  localparam int CW      = $clog2(SAT + 1),
  localparam int RCW     = $clog2(TRRD + 1) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             ras_ni,
  input  logic             cas_ni,
  input  logic             we_ni,
  input  logic [BW-1:0]    bank_i,
  input  logic [RW-1:0]    addr_i,
  output logic             cmd_ok_o,
  output logic [NB-1:0]    open_o,
  output logic [NB*RW-1:0] open_rows_o,
  output logic             err_o,
  output logic [2:0]       err_code_o,
  output logic [BW-1:0]    err_bank_o
);
  cmd_e                  cmd;
  err_e                  code;
  logic [NB-1:0]         act_go, pre_go, ras_hit;
  logic [NB-1:0][CW-1:0] cnt;
  logic [NB-1:0][RW-1:0] rows;
  logic [RCW-1:0]        rrd_cnt;
  logic [BW-1:0]         last_bank;

  sag_decode u_dec (
    .cs_ni (cs_ni),
    .ras_ni(ras_ni),
    .cas_ni(cas_ni),
    .we_ni (we_ni),
    .cmd_o (cmd)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    sag_bank #(.RW(RW), .CW(CW), .SAT(SAT)) u_bank (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .act_i (act_go[b]),
      .pre_i (pre_go[b]),
      .row_i (addr_i),
      .open_o(open_o[b]),
      .row_o (rows[b]),
      .cnt_o (cnt[b])
    );
  end

  sag_rrd #(.BW(BW), .TRRD(TRRD)) u_rrd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .act_i      (|act_go),
    .bank_i     (bank_i),
    .cnt_o      (rrd_cnt),
    .last_bank_o(last_bank)
  );

  sag_rules #(
    .NB(NB), .BW(BW), .CW(CW), .RCW(RCW),
    .TRCD(TRCD), .TRC(TRC), .TRRD(TRRD), .TRAS_MAX(TRAS_MAX)
  ) u_rules (
    .cmd_i      (cmd),
    .bank_i     (bank_i),
    .open_i     (open_o),
    .cnt_i      (cnt),
    .rrd_cnt_i  (rrd_cnt),
    .last_bank_i(last_bank),
    .code_o     (code),
    .act_go_o   (act_go),
    .pre_go_o   (pre_go),
    .ras_hit_o  (ras_hit)
  );

  assign cmd_ok_o    = (code == ERR_NONE);
  assign open_rows_o = rows;

  // lowest bank wins if several rows expire together
  logic [BW-1:0] ras_bank;
  always_comb begin
    ras_bank = '0;
    for (int b = NB - 1; b >= 0; b--) if (ras_hit[b]) ras_bank = BW'(b);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_o      <= 1'b0;
      err_code_o <= ERR_NONE;
      err_bank_o <= '0;
    end else if (code != ERR_NONE) begin
      err_o      <= 1'b1;
      err_code_o <= code;
      err_bank_o <= bank_i;
    end else if (|ras_hit) begin
      err_o      <= 1'b1;
      err_code_o <= ERR_RASMAX;
      err_bank_o <= ras_bank;
    end else begin
      err_o      <= 1'b0;
      err_code_o <= ERR_NONE;
      err_bank_o <= '0;
    end
  end
endmodule

// File: rtl/sag_checker.sv
module sag_checker #(
  parameter int NB = 4,
  parameter int BW = 2,
  parameter int RW = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cs_ni,
  input logic             ras_ni,
  input logic             cas_ni,
  input logic             we_ni,
  input logic [BW-1:0]    bank_i,
  input logic             cmd_ok_o,
  input logic [NB-1:0]    open_o,
  input logic [NB*RW-1:0] open_rows_o,
  input logic             err_o,
  input logic [2:0]       err_code_o
);
  logic is_act, is_rw, is_pre, is_nop;
  assign is_act = !cs_ni && !ras_ni &&  cas_ni &&  we_ni;
  assign is_rw  = !cs_ni &&  ras_ni && !cas_ni;
  assign is_pre = !cs_ni && !ras_ni &&  cas_ni && !we_ni;
  assign is_nop = !(is_act || is_rw || is_pre);

  AST_ACT_OPENS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_act && cmd_ok_o) |=> open_o[$past(bank_i)]); // R2
  AST_ACT_OPEN_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_act && open_o[bank_i]) |=> (err_o && err_code_o == 3'd5)); // R3
  AST_PRE_CLOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_pre |=> !open_o[$past(bank_i)]); // R4
  AST_RW_CLOSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_rw && !open_o[bank_i]) |=> (err_o && err_code_o == 3'd1)); // R5
  AST_NOP_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_nop || !cmd_ok_o) |=> ($stable(open_o) && $stable(open_rows_o))); // R9
  AST_CODE_MATCHES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o == (err_code_o != 3'd0)); // R10
  AST_NOP_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_nop |-> cmd_ok_o); // R11
endmodule

bind sdram_act_guard sag_checker #(.NB(NB), .BW(BW), .RW(RW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_ni      (cs_ni),
  .ras_ni     (ras_ni),
  .cas_ni     (cas_ni),
  .we_ni      (we_ni),
  .bank_i     (bank_i),
  .cmd_ok_o   (cmd_ok_o),
  .open_o     (open_o),
  .open_rows_o(open_rows_o),
  .err_o      (err_o),
  .err_code_o (err_code_o)
);

// File: tb/tb_sdram_act_guard.sv
`timescale 1ns/1ps
module tb_sdram_act_guard;
  localparam int TRCD = 3, TRC = 7, TRRD = 2, TRAS_MAX = 30;
  localparam logic [2:0] P_ACT = 3'b011, P_RD = 3'b101, P_WR = 3'b100, P_PRE = 3'b010;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] bank = '0;
  logic [11:0] addr = '0;
  logic cmd_ok, err;
  logic [3:0] open;
  logic [47:0] rows;
  logic [2:0] code;
  logic [1:0] ebank;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sdram_act_guard #(.TRCD(TRCD), .TRC(TRC), .TRRD(TRRD), .TRAS_MAX(TRAS_MAX)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .ras_ni(ras_n), .cas_ni(cas_n),
    .we_ni(we_n), .bank_i(bank), .addr_i(addr), .cmd_ok_o(cmd_ok), .open_o(open),
    .open_rows_o(rows), .err_o(err), .err_code_o(code), .err_bank_o(ebank)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one edge: drive pins, check cmd_ok before edge, error after edge
  task automatic do_cmd(string req, logic [2:0] rcw, logic [1:0] b, logic [11:0] r,
                        logic exp_ok, logic [2:0] exp_code);
    @(negedge clk);
    cs_n = 1'b0; {ras_n, cas_n, we_n} = rcw; bank = b; addr = r;
    #1 chk({req, " ok"}, 32'(cmd_ok), 32'(exp_ok));
    @(posedge clk); #1;
    chk({req, " err"}, 32'(err), 32'(exp_code != 3'd0));
    chk({req, " code"}, 32'(code), 32'(exp_code));
    if (exp_code != 3'd0) chk({req, " bank"}, 32'(ebank), 32'(b));
    cs_n = 1'b1; {ras_n, cas_n, we_n} = 3'b111;
  endtask

  task automatic nop_n(int n, bit watch);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cs_n = 1'b1;
      @(posedge clk); #1;
      if (watch) chk("R8 no early pulse", 32'(err), 32'd0);
    end
  endtask

  task automatic close_all();
    for (int b = 0; b < 4; b++) do_cmd("R4 close", P_PRE, 2'(b), 12'h0, 1'b1, 3'd0);
    chk("R4 all closed", 32'(open), 32'h0);
  endtask

  task automatic t_reset();
    chk("R12 closed at reset", 32'(open), 32'h0);
    chk("R10 no err at reset", 32'(err), 32'd0);
    do_cmd("R12 first act", P_ACT, 2'd2, 12'h055, 1'b1, 3'd0);
    chk("R12 b2 open", 32'(open), 32'h4);
    do_cmd("R4 pre b2", P_PRE, 2'd2, 12'h0, 1'b1, 3'd0);
  endtask

  task automatic t_decode();
    @(negedge clk); cs_n = 1'b1; {ras_n, cas_n, we_n} = P_ACT; bank = 2'd1; addr = 12'h321;
    #1 chk("R11 cs high legal", 32'(cmd_ok), 32'd1);
    @(posedge clk); #1;
    chk("R1 cs high is nop", 32'(open), 32'h0);
    chk("R9 nop no err", 32'(err), 32'd0);
    @(negedge clk); cs_n = 1'b0; {ras_n, cas_n, we_n} = 3'b001;
    #1 chk("R11 other pattern legal", 32'(cmd_ok), 32'd1);
    @(posedge clk); #1;
    chk("R1 pattern 001 is nop", 32'(open), 32'h0);
    cs_n = 1'b1;
    do_cmd("R4 pre closed bank", P_PRE, 2'd1, 12'h0, 1'b1, 3'd0);
  endtask

  task automatic t_rcd();
    do_cmd("R2 act b0", P_ACT, 2'd0, 12'h123, 1'b1, 3'd0);
    chk("R2 b0 open", 32'(open), 32'h1);
    chk("R2 b0 row", 32'(rows[11:0]), 32'h123);
    nop_n(1, 1'b0);
    do_cmd("R5 read early", P_RD, 2'd0, 12'h0, 1'b0, 3'd1);
    do_cmd("R5 write at trcd", P_WR, 2'd0, 12'h0, 1'b1, 3'd0);
    do_cmd("R3 act open", P_ACT, 2'd0, 12'h0ab, 1'b0, 3'd5);
    chk("R9 row kept", 32'(rows[11:0]), 32'h123);
    do_cmd("R5 read closed", P_RD, 2'd1, 12'h0, 1'b0, 3'd1);
    close_all();
  endtask

  task automatic t_rrd();
    do_cmd("R7 act b1", P_ACT, 2'd1, 12'h011, 1'b1, 3'd0);
    do_cmd("R7 act b2 early", P_ACT, 2'd2, 12'h022, 1'b0, 3'd3);
    chk("R9 b2 still closed", 32'(open), 32'h2);
    do_cmd("R7 act b2 at trrd", P_ACT, 2'd2, 12'h022, 1'b1, 3'd0);
    chk("R2 b1 b2 open", 32'(open), 32'h6);
    chk("R2 b2 row", 32'(rows[35:24]), 32'h022);
  endtask

  task automatic t_rc();
    nop_n(2, 1'b0);
    do_cmd("R6 act b3", P_ACT, 2'd3, 12'h0f0, 1'b1, 3'd0);
    do_cmd("R6 pre b3", P_PRE, 2'd3, 12'h0, 1'b1, 3'd0);
    do_cmd("R6 reopen early", P_ACT, 2'd3, 12'h0f1, 1'b0, 3'd2);
    nop_n(4, 1'b0);
    do_cmd("R6 reopen at trc", P_ACT, 2'd3, 12'h0f1, 1'b1, 3'd0);
    chk("R6 b3 row", 32'(rows[47:36]), 32'h0f1);
    close_all();
  endtask

  task automatic t_ras();
    do_cmd("R8 act b0", P_ACT, 2'd0, 12'h0aa, 1'b1, 3'd0);
    nop_n(TRAS_MAX, 1'b1);
    nop_n(1, 1'b0);
    chk("R8 pulse", 32'(err), 32'd1);
    chk("R8 code", 32'(code), 32'd4);
    chk("R8 bank", 32'(ebank), 32'd0);
    nop_n(1, 1'b0);
    chk("R10 single pulse", 32'(err), 32'd0);
    do_cmd("R8 pre b0", P_PRE, 2'd0, 12'h0, 1'b1, 3'd0);
    do_cmd("R8 act b1", P_ACT, 2'd1, 12'h0bb, 1'b1, 3'd0);
    nop_n(TRAS_MAX, 1'b1);
    do_cmd("R8 pre on limit edge", P_PRE, 2'd1, 12'h0, 1'b1, 3'd0);
    nop_n(3, 1'b1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset_pre: begin
      chk("R12 closed in reset", 32'(open), 32'h0);
    end
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_decode();
    t_rcd();
    t_rrd();
    t_rc();
    t_ras();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule